// File: doc/BRIEF.md
# Secondary-Cache Hit Bus Responder

This block sequences the bus side of a look-aside secondary cache that sits on a split-transaction processor bus next to a memory controller. It samples every transfer-start strobe together with a hit/miss answer from an external tag lookup. On a hit it claims the transaction, so the memory controller stands back, and it produces the address acknowledge. It then runs a four-beat burst on the 64-bit data bus and produces one transfer acknowledge per beat.

A read hit sends data from a combinational data-RAM read port onto the bus. The bus drive and the data-bus-busy drive are modelled as output enables that are high only while the cache's own beats are in progress. A write hit writes the processor's data into the data-RAM write port, one doubleword per beat. The data phase waits for a qualified data-bus grant, and that grant never shifts the claim or the address acknowledge. One transaction can be held waiting while an earlier data tenure drains. The address reaches the block as a doubleword address (bus address bits 31 down to 3), and the data-RAM ports use the same doubleword address space.

Top module: `l2_hit_responder`

## Requirements
- R1: While reset is applied and afterwards with no transfer start, claim, aack, ta, dbb_out, dbb_oe, data_oe and ram_wr_en are all low.
- R2: A hit transfer start that is accepted raises claim in the next cycle. claim stays high through the cycle after the aack cycle and is low in the cycle after that.
- R3: If a hit transfer start arrives while no data tenure is active, aack is high for exactly one cycle, the cycle after the start. A tenure in its fourth beat counts as not active.
- R4: If dbg_q is high in the same cycle as an immediately acknowledged hit start, the first ta is in the next cycle.
- R5: Without that grant, the first ta comes in the cycle after the first cycle in which dbg_q is sampled high. The cycles of claim and aack do not depend on dbg_q.
- R6: ta is high on exactly four consecutive cycles. The beat index (dw_addr bits 1:0) starts at the start address's bits 1:0 and counts up modulo 4. The RAM address is {dw_addr[28:2] of the start, beat index}.
- R7: During a read hit's ta cycles, data_oe, dbb_oe and dbb_out are high and data_out equals ram_rd_data at ram_rd_addr. data_oe and dbb_oe are low in every cycle without ta.
- R8: During a write hit's ta cycles, ram_wr_en is high, ram_wr_addr follows the beat order and ram_wr_data equals data_in. data_oe and dbb_oe stay low throughout.
- R9: A transfer start with tag_hit low produces no claim, aack, ta or RAM write.
- R10: If a hit start arrives while a tenure is active and not in its fourth beat, claim rises in the next cycle and aack comes in the cycle after that tenure's fourth ta. The grant for the waiting transaction is sampled from its aack cycle onward.
- R11: A transfer start that arrives while claim is high is ignored and produces no further claim, aack or ta.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ts | input | 1 | Transfer-start strobe |
| dw_addr | input | 29 | Doubleword address of the transfer (bus address bits 31..3) |
| is_write | input | 1 | Transfer is a write, sampled with ts |
| tag_hit | input | 1 | Tag lookup result for the address presented with ts |
| dbg_q | input | 1 | Qualified data-bus grant |
| claim | output | 1 | Cache owns the current transaction |
| aack | output | 1 | Address acknowledge |
| ta | output | 1 | Transfer acknowledge, one per beat |
| dbb_out | output | 1 | Data-bus-busy value driven by the cache |
| dbb_oe | output | 1 | Output enable for dbb_out |
| data_out | output | 64 | Read data driven onto the bus |
| data_oe | output | 1 | Output enable for data_out |
| data_in | input | 64 | Processor-driven data bus |
| ram_rd_addr | output | 29 | Data-RAM read address |
| ram_rd_data | input | 64 | Data-RAM read data, combinational |
| ram_wr_en | output | 1 | Data-RAM write strobe |
| ram_wr_addr | output | 29 | Data-RAM write address |
| ram_wr_data | output | 64 | Data-RAM write data |

## Verification
The hardest case to reach is the overlap between an address phase and a data tenure that is still draining. Here a second start lands mid-burst and must hold its acknowledge, while a grant held high throughout must not start its beats early. The case right beside it is a start in the fourth-beat cycle, which must be acknowledged at once. The bench places the second start at chosen cycle offsets against a burst whose timing is known, with the grant held constant or pulsed late. A sweep over critical beat, direction and grant delay covers the single-transaction timing.

// File: rtl/l2r_pkg.sv
`timescale 1ns/1ps
// Package l2r_pkg: state encodings shared by the responder's sequencers.
// Assumes nothing beyond two small state machines.
package l2r_pkg;
    typedef enum logic [1:0] {A_IDLE, A_WAIT, A_ACK, A_HOLD} addr_st_t;
    typedef enum logic [1:0] {D_IDLE, D_GRANT, D_BEAT} data_st_t;
endpackage

// File: rtl/l2r_addr_seq.sv
`timescale 1ns/1ps
// Module l2r_addr_seq: address-phase sequencer. Accepts a hit transfer
// start when no address phase is in progress. It raises claim the next
// cycle and places aack either at once or after the running data tenure's
// final beat, then holds claim one more cycle.
// Assumes the tag answer is valid in the ts cycle; one waiting start max.
module l2r_addr_seq
    import l2r_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ts,
    input  logic tag_hit,
    input  logic data_idle,
    input  logic data_last,
    output logic claim,
    output logic aack,
    output logic take_now,
    output logic take_defer,
    output logic pend_go
);
    addr_st_t st, st_nx;
    logic     accept;
    logic     free;

    // Decide whether a start is taken and whether its acknowledge can go at once.
    always_comb begin
        accept     = ts && tag_hit && (st == A_IDLE);
        free       = data_idle || data_last;
        take_now   = accept && free;
        take_defer = accept && !free;
        pend_go    = (st == A_WAIT) && data_last;
    end

    // Next-state selection for the address phase.
    always_comb begin
        st_nx = st;
        case (st)
            A_IDLE:  if (take_now) st_nx = A_ACK;
                     else if (take_defer) st_nx = A_WAIT;
            A_WAIT:  if (data_last) st_nx = A_ACK;
            A_ACK:   st_nx = A_HOLD;
            default: st_nx = A_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= A_IDLE;
        else        st <= st_nx;
    end

    // Output decode from the registered state.
    always_comb begin
        claim = (st != A_IDLE);
        aack  = (st == A_ACK);
    end

    // R2
    claim_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ts && tag_hit && !claim) |=> claim);
    // R2
    claim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aack |=> (claim && !aack));
    // R3
    aack_prompt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ts && tag_hit && !claim && data_idle) |=> aack);
    // R10
    aack_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ts && tag_hit && !claim && !data_idle && !data_last) |=> (claim && !aack));
    // R9
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ts && !tag_hit && !claim) |=> !claim);
endmodule

// File: rtl/l2r_data_seq.sv
`timescale 1ns/1ps
// Module l2r_data_seq: data-phase sequencer. Holds the running and the
// waiting transaction and waits for a qualified grant. It then issues
// BEATS consecutive beats, starting at the critical beat and wrapping
// inside the line.
// Assumes BEATS is a power of two and at most one transaction waits.
module l2r_data_seq
    import l2r_pkg::*;
#(
    parameter int BLK_W  = 27,
    parameter int BEATS  = 4,
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_now,
    input  logic              take_defer,
    input  logic              pend_go,
    input  logic              dbg_q,
    input  logic              wr_in,
    input  logic [BLK_W-1:0]  blk_in,
    input  logic [BEAT_W-1:0] crit_in,
    output logic              ta,
    output logic              cur_wr,
    output logic [BLK_W-1:0]  cur_blk,
    output logic [BEAT_W-1:0] beat,
    output logic              data_idle,
    output logic              data_last
);
    localparam logic [BEAT_W-1:0] LAST_CNT = BEAT_W'(BEATS - 1);

    data_st_t          st;
    logic [BEAT_W-1:0] cnt;
    logic              pend_wr;
    logic [BLK_W-1:0]  pend_blk;
    logic [BEAT_W-1:0] pend_crit;

    // Status decode used by the address sequencer and the outputs.
    always_comb begin
        ta        = (st == D_BEAT);
        data_idle = (st == D_IDLE);
        data_last = (st == D_BEAT) && (cnt == LAST_CNT);
    end

    // Load, grant wait and beat counting for the active tenure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= D_IDLE;
            cnt     <= '0;
            beat    <= '0;
            cur_wr  <= 1'b0;
            cur_blk <= '0;
        end else if (take_now) begin
            st      <= dbg_q ? D_BEAT : D_GRANT;
            cnt     <= '0;
            beat    <= crit_in;
            cur_wr  <= wr_in;
            cur_blk <= blk_in;
        end else if (pend_go) begin
            st      <= D_GRANT;
            cnt     <= '0;
            beat    <= pend_crit;
            cur_wr  <= pend_wr;
            cur_blk <= pend_blk;
        end else begin
            case (st)
                D_GRANT: if (dbg_q) st <= D_BEAT;
                D_BEAT: begin
                    cnt  <= cnt + 1'b1;
                    beat <= beat + 1'b1;
                    if (cnt == LAST_CNT) st <= D_IDLE;
                end
                default: st <= D_IDLE;
            endcase
        end
    end

    // Capture of a start whose acknowledge must wait for the running tenure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_wr   <= 1'b0;
            pend_blk  <= '0;
            pend_crit <= '0;
        end else if (take_defer) begin
            pend_wr   <= wr_in;
            pend_blk  <= blk_in;
            pend_crit <= crit_in;
        end
    end

    // R4
    grant_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_now && dbg_q) |=> (ta && beat == $past(crit_in)));
    // R5
    grant_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == D_GRANT && !dbg_q && !take_now && !pend_go) |=> !ta);
    // R6
    beat_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ta && !data_last) |=> (ta && cur_blk == $past(cur_blk)));
endmodule

// File: rtl/l2_hit_responder.sv
`timescale 1ns/1ps
// Module l2_hit_responder: top of the secondary-cache hit responder. Splits
// the doubleword address into line and critical beat, joins the address-
// and data-phase sequencers, and routes read data to the bus and write
// data to the data RAM during the cache's own beats.
// Assumes a combinational RAM read port and a 64-bit, four-beat burst.
module l2_hit_responder
    import l2r_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int BEATS  = 4,
    localparam int OFF_W  = $clog2(DATA_W / 8),
    localparam int DW_W   = ADDR_W - OFF_W,
    localparam int BEAT_W = $clog2(BEATS),
    localparam int BLK_W  = DW_W - BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ts,
    input  logic [DW_W-1:0]   dw_addr,
    input  logic              is_write,
    input  logic              tag_hit,
    input  logic              dbg_q,
    output logic              claim,
    output logic              aack,
    output logic              ta,
    output logic              dbb_out,
    output logic              dbb_oe,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic [DATA_W-1:0] data_in,
    output logic [DW_W-1:0]   ram_rd_addr,
    input  logic [DATA_W-1:0] ram_rd_data,
    output logic              ram_wr_en,
    output logic [DW_W-1:0]   ram_wr_addr,
    output logic [DATA_W-1:0] ram_wr_data
);
    logic              take_now, take_defer, pend_go;
    logic              data_idle, data_last;
    logic              cur_wr;
    logic [BLK_W-1:0]  cur_blk;
    logic [BEAT_W-1:0] beat;

    l2r_addr_seq u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ts         (ts),
        .tag_hit    (tag_hit),
        .data_idle  (data_idle),
        .data_last  (data_last),
        .claim      (claim),
        .aack       (aack),
        .take_now   (take_now),
        .take_defer (take_defer),
        .pend_go    (pend_go)
    );

    l2r_data_seq #(.BLK_W(BLK_W), .BEATS(BEATS)) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_now   (take_now),
        .take_defer (take_defer),
        .pend_go    (pend_go),
        .dbg_q      (dbg_q),
        .wr_in      (is_write),
        .blk_in     (dw_addr[DW_W-1:BEAT_W]),
        .crit_in    (dw_addr[BEAT_W-1:0]),
        .ta         (ta),
        .cur_wr     (cur_wr),
        .cur_blk    (cur_blk),
        .beat       (beat),
        .data_idle  (data_idle),
        .data_last  (data_last)
    );

    // Bus drive and RAM strobes limited to the cache's own beats.
    always_comb begin
        ram_rd_addr = {cur_blk, beat};
        ram_wr_addr = {cur_blk, beat};
        ram_wr_data = data_in;
        ram_wr_en   = ta && cur_wr;
        data_oe     = ta && !cur_wr;
        dbb_oe      = ta && !cur_wr;
        dbb_out     = ta;
        data_out    = ram_rd_data;
    end

    // R7
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (ta && dbb_oe && !ram_wr_en));
    // R8
    write_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_en |-> (!data_oe && !dbb_oe && ta));
    // R1
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ta |-> (!data_oe && !dbb_oe && !ram_wr_en && !dbb_out));
    // R3
    aack_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aack |-> claim);
endmodule

// File: tb/sim_l2_hit_responder.sv
`timescale 1ns/1ps
// Bench sim_l2_hit_responder: cycle-exact scenario tables checked every cycle.
module sim_l2_hit_responder;
    localparam int NC = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ts = 1'b0, is_write = 1'b0, tag_hit = 1'b0, dbg_q = 1'b0;
    logic [28:0] dw_addr = '0;
    logic [63:0] data_in = '0;
    logic        claim, aack, ta, dbb_out, dbb_oe, data_oe, ram_wr_en;
    logic [63:0] data_out, ram_rd_data, ram_wr_data;
    logic [28:0] ram_rd_addr, ram_wr_addr;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    // stimulus and expectation tables, indexed by cycle within a scenario
    logic        s_ts[NC], s_hit[NC], s_dbg[NC], s_wr[NC];
    logic [28:0] s_addr[NC];
    logic        e_claim[NC], e_aack[NC], e_ta[NC], e_wr[NC];
    logic [28:0] e_addr[NC];

    always #2.5 clk = ~clk;

    function automatic logic [63:0] pat(input logic [28:0] a);
        return {3'b101, a, ~a, 3'b010};
    endfunction
    function automatic logic [63:0] din_of(input int c);
        return {32'hD000_0000 | 32'(c), 32'h0000_0E00 | 32'(c)};
    endfunction

    assign ram_rd_data = pat(ram_rd_addr);

    l2_hit_responder u0 (
        .clk(clk), .rst_n(rst_n), .ts(ts), .dw_addr(dw_addr), .is_write(is_write),
        .tag_hit(tag_hit), .dbg_q(dbg_q), .claim(claim), .aack(aack), .ta(ta),
        .dbb_out(dbb_out), .dbb_oe(dbb_oe), .data_out(data_out), .data_oe(data_oe),
        .data_in(data_in), .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data),
        .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    task automatic clr();
        for (int c = 0; c < NC; c++) begin
            s_ts[c] = 0; s_hit[c] = 1; s_dbg[c] = 0; s_wr[c] = 0; s_addr[c] = '0;
            e_claim[c] = 0; e_aack[c] = 0; e_ta[c] = 0; e_wr[c] = 0; e_addr[c] = '0;
        end
    endtask

    // one transaction: start cycle, claim window, aack cycle, first beat cycle
    task automatic add_tx(input int t0, input int crit, input int blk, input bit wr,
                          input int cl0, input int ak, input int ta0);
        s_ts[t0] = 1; s_wr[t0] = wr; s_addr[t0] = {27'(blk), 2'(crit)};
        for (int c = cl0; c <= ak + 1; c++) e_claim[c] = 1;
        e_aack[ak] = 1;
        for (int i = 0; i < 4; i++) begin
            e_ta[ta0 + i] = 1; e_wr[ta0 + i] = wr;
            e_addr[ta0 + i] = {27'(blk), 2'((crit + i) % 4)};
        end
    endtask

    task automatic run(input int n);
        for (int c = 0; c < n; c++) begin
            cyc = c;
            ts = s_ts[c]; tag_hit = s_hit[c]; dbg_q = s_dbg[c];
            is_write = s_wr[c]; dw_addr = s_addr[c]; data_in = din_of(c);
            @(negedge clk);
            chk("R2 claim", claim, e_claim[c]);
            chk("R3 aack", aack, e_aack[c]);
            chk("R6 ta", ta, e_ta[c]);
            chk("R7 data_oe", data_oe, e_ta[c] && !e_wr[c]);
            chk("R7 dbb_oe", dbb_oe, e_ta[c] && !e_wr[c]);
            chk("R8 ram_wr_en", ram_wr_en, e_ta[c] && e_wr[c]);
            if (e_ta[c] && !e_wr[c]) begin
                chk("R6 rd_addr", ram_rd_addr, e_addr[c]);
                chk("R7 data_out", data_out, pat(e_addr[c]));
                chk("R7 dbb_out", dbb_out, 1'b1);
            end
            if (e_ta[c] && e_wr[c]) begin
                chk("R6 wr_addr", ram_wr_addr, e_addr[c]);
                chk("R8 wr_data", ram_wr_data, din_of(c));
            end
            @(posedge clk); #0.5;
        end
        ts = 0; dbg_q = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: quiet in and after reset
        repeat (3) @(posedge clk);
        #0.5;
        @(negedge clk);
        chk("R1 reset claim", claim, 0); chk("R1 reset aack", aack, 0);
        chk("R1 reset ta", ta, 0); chk("R1 reset oe", {dbb_oe, data_oe, ram_wr_en}, 0);
        @(posedge clk); #0.5; rst_n = 1;
        clr(); run(3);

        // R4, R5, R6, R7, R8: sweep critical beat, direction and grant delay
        for (int crit = 0; crit < 4; crit++)
            for (int wr = 0; wr < 2; wr++)
                for (int gd = 0; gd < 4; gd++) begin
                    clr();
                    add_tx(0, crit, crit * 9 + gd * 5 + wr + 1, wr[0], 1, 1, gd + 1);
                    s_dbg[gd] = 1;
                    run(gd + 7);
                end

        // R9: miss leaves the bus alone, the next hit is then served
        clr();
        s_ts[0] = 1; s_hit[0] = 0; s_dbg[0] = 1; s_addr[0] = 29'h155;
        add_tx(1, 2, 77, 0, 2, 2, 3);
        s_dbg[2] = 1;
        run(9);

        // R10, R11: start during hold ignored, start mid-burst deferred, grant held high
        clr();
        add_tx(0, 1, 300, 0, 1, 1, 1);
        s_ts[2] = 1; s_addr[2] = 29'h1ABCDE;
        add_tx(3, 3, 301, 1, 4, 5, 6);
        for (int c = 0; c < 12; c++) s_dbg[c] = 1;
        run(12);

        // R3: start in the final-beat cycle is acknowledged at once
        clr();
        add_tx(0, 0, 512, 1, 1, 1, 1);
        s_dbg[0] = 1;
        add_tx(4, 2, 513, 0, 5, 5, 5);
        s_dbg[4] = 1;
        run(11);

        // R10, R5: deferred start whose grant arrives late
        clr();
        add_tx(0, 3, 900, 0, 1, 1, 1);
        s_dbg[0] = 1;
        add_tx(3, 1, 901, 1, 4, 5, 8);
        s_dbg[7] = 1;
        run(14);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule